// File: doc/BRIEF.md
# Serial Peripheral Clock Request Controller

This block decides, for a group of serial peripherals, whether the fast subsystem clock has to keep running while the device is in a low-power state. Each peripheral picks its clock source: the fast subsystem clock or the slow auxiliary clock. It also reports whether it is busy, whether it is the bus master, and whether its software reset is held. The block turns these inputs into a device-wide override for the fast clock and into one internal clock enable per peripheral.

When a master peripheral on the fast source is busy, the fast clock is forced on for the whole device, whatever software has programmed. The force is held for a fixed number of cycles after busy is last sampled high, so the final bit can complete. After that, the clock follows the software enable and the low-power gate again. A peripheral on the slow source gets no override, and neither does a peripheral in slave mode, because its bit clock comes from the external master. A slave needs no internal clock at all.

Top module: `clkreq_ctrl`

## Requirements
- R1: While reset is asserted and on the first cycle after it, `fast_override_o` is 0, and `fast_clk_on_o` follows only the software enable and the fast low-power gate.
- R2: If a clock edge samples peripheral c with master=1, source fast (`src_slow_i[c]`=0), busy=1 and software reset=0, then `fast_override_o` is 1 after that edge for as long as c stays a master on the fast source and out of reset.
- R3: Once busy stops being sampled high, the override from a peripheral stays on for exactly HOLD_CYCLES further edges. A busy burst sampled on L edges therefore gives an override lasting L+HOLD_CYCLES-1 cycles (L+1 with the default of 2).
- R4: When no override is active, `fast_clk_on_o` = `sw_fast_en_i` AND NOT `lp_fast_off_i`.
- R5: A peripheral whose `src_slow_i` bit is 1 (slow auxiliary source) never produces an override, and the slow clock is never forced.
- R6: The override acts device-wide. While `fast_override_o` is 1, `fast_clk_on_o` is 1 even when software has disabled the fast clock and the low-power gate is off, and every other master peripheral on the fast source sees its clock enabled.
- R7: A slave peripheral (`master_i[c]`=0) makes no clock request and its `periph_clk_en_o[c]` is 0. A slave that is busy while every clock is disabled leaves all clock outputs at 0.
- R8: When `swrst_i[c]` is 1, that peripheral's override is removed in the same cycle and its pending hold is discarded, so the override does not come back after the reset is released.
- R9: `periph_clk_en_o[c]` is 1 only for a master. It equals `fast_clk_on_o` when that master's source is fast and `slow_clk_on_o` when its source is slow.
- R10: `slow_clk_on_o` = `sw_slow_en_i` AND NOT `lp_slow_off_i`. It is never overridden.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| src_slow_i | input | NUM_PERIPH | Per-peripheral source select: 0 fast, 1 slow |
| master_i | input | NUM_PERIPH | Per-peripheral master mode: 1 master, 0 slave |
| busy_i | input | NUM_PERIPH | Per-peripheral busy indication |
| swrst_i | input | NUM_PERIPH | Per-peripheral software reset |
| sw_fast_en_i | input | 1 | Software enable for the fast clock |
| sw_slow_en_i | input | 1 | Software enable for the slow clock |
| lp_fast_off_i | input | 1 | Low-power state gates the fast clock off |
| lp_slow_off_i | input | 1 | Low-power state gates the slow clock off |
| fast_override_o | output | 1 | Device-wide force of the fast clock |
| fast_clk_on_o | output | 1 | Effective fast clock enable |
| slow_clk_on_o | output | 1 | Effective slow clock enable |
| periph_clk_en_o | output | NUM_PERIPH | Per-peripheral internal clock enable |

## Verification
Several properties are checked on every cycle: an override only exists while some master on the fast source is out of reset; an override always turns the fast clock on; an idle block hands fast-clock control back to software; slaves never get an internal clock; and HOLD_CYCLES edges without a request always end the override. A sampled request must also produce the override on the next cycle. Only the bench scenarios show the exact length of an override for busy bursts of different lengths, that a software reset discards a pending hold, and that a busy slave with every clock gated leaves everything off. Two full sweeps over every input combination compare all outputs against a cycle model of the hold counters.

// File: rtl/clkreq_pkg.sv
package clkreq_pkg;
  typedef enum logic {
    SRC_FAST = 1'b0,
    SRC_SLOW = 1'b1
  } clk_src_e;
endpackage

// File: rtl/clkreq_hold.sv
module clkreq_hold
  import clkreq_pkg::*;
#(
  parameter int unsigned HOLD_CYCLES = 2
) (
  input  logic     clk_i,
  input  logic     rst_ni,
  input  clk_src_e src_i,
  input  logic     master_i,
  input  logic     busy_i,
  input  logic     swrst_i,
  output logic     force_o
);
  localparam int unsigned CW = $clog2(HOLD_CYCLES + 1);
  localparam logic [CW-1:0] HOLD_LD = CW'(HOLD_CYCLES);

  logic          eligible;
  logic          want;
  logic [CW-1:0] cnt_q;

  assign eligible = master_i && (src_i == SRC_FAST) && !swrst_i;
  assign want     = eligible && busy_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (swrst_i) begin
      cnt_q <= '0;
    end else if (want) begin
      cnt_q <= HOLD_LD;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  // mask combinationally so reset/source change take effect at once
  assign force_o = (cnt_q != '0) && eligible;
endmodule

// File: rtl/clkreq_gate.sv
module clkreq_gate #(
  parameter int unsigned NUM_PERIPH = 2
) (
  input  logic [NUM_PERIPH-1:0] force_i,
  input  logic [NUM_PERIPH-1:0] src_slow_i,
  input  logic [NUM_PERIPH-1:0] master_i,
  input  logic                  sw_fast_en_i,
  input  logic                  sw_slow_en_i,
  input  logic                  lp_fast_off_i,
  input  logic                  lp_slow_off_i,
  output logic                  fast_override_o,
  output logic                  fast_clk_on_o,
  output logic                  slow_clk_on_o,
  output logic [NUM_PERIPH-1:0] periph_clk_en_o
);
  logic fast_sw_on;

  assign fast_override_o = |force_i;
  assign fast_sw_on      = sw_fast_en_i && !lp_fast_off_i;
  assign fast_clk_on_o   = fast_sw_on || fast_override_o;
  assign slow_clk_on_o   = sw_slow_en_i && !lp_slow_off_i;

  for (genvar c = 0; c < NUM_PERIPH; c++) begin : g_pen
    assign periph_clk_en_o[c] = master_i[c] &&
                                (src_slow_i[c] ? slow_clk_on_o : fast_clk_on_o);
  end
endmodule

// File: rtl/clkreq_ctrl.sv
module clkreq_ctrl
  import clkreq_pkg::*;
#(
  parameter int unsigned NUM_PERIPH  = 2,
  parameter int unsigned HOLD_CYCLES = 2
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [NUM_PERIPH-1:0] src_slow_i,
  input  logic [NUM_PERIPH-1:0] master_i,
  input  logic [NUM_PERIPH-1:0] busy_i,
  input  logic [NUM_PERIPH-1:0] swrst_i,
  input  logic                  sw_fast_en_i,
  input  logic                  sw_slow_en_i,
  input  logic                  lp_fast_off_i,
  input  logic                  lp_slow_off_i,
  output logic                  fast_override_o,
  output logic                  fast_clk_on_o,
  output logic                  slow_clk_on_o,
  output logic [NUM_PERIPH-1:0] periph_clk_en_o
);
  logic [NUM_PERIPH-1:0] force_w;

  for (genvar c = 0; c < NUM_PERIPH; c++) begin : g_ch
    clkreq_hold #(
      .HOLD_CYCLES(HOLD_CYCLES)
    ) u_hold (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .src_i   (clk_src_e'(src_slow_i[c])),
      .master_i(master_i[c]),
      .busy_i  (busy_i[c]),
      .swrst_i (swrst_i[c]),
      .force_o (force_w[c])
    );
  end

  clkreq_gate #(
    .NUM_PERIPH(NUM_PERIPH)
  ) u_gate (
    .force_i        (force_w),
    .src_slow_i     (src_slow_i),
    .master_i       (master_i),
    .sw_fast_en_i   (sw_fast_en_i),
    .sw_slow_en_i   (sw_slow_en_i),
    .lp_fast_off_i  (lp_fast_off_i),
    .lp_slow_off_i  (lp_slow_off_i),
    .fast_override_o(fast_override_o),
    .fast_clk_on_o  (fast_clk_on_o),
    .slow_clk_on_o  (slow_clk_on_o),
    .periph_clk_en_o(periph_clk_en_o)
  );
endmodule

// File: rtl/clkreq_ctrl_chk.sv
module clkreq_ctrl_chk #(
  parameter int unsigned NUM_PERIPH  = 2,
  parameter int unsigned HOLD_CYCLES = 2
) (
  input logic                  clk_i,
  input logic                  rst_ni,
  input logic [NUM_PERIPH-1:0] src_slow_i,
  input logic [NUM_PERIPH-1:0] master_i,
  input logic [NUM_PERIPH-1:0] busy_i,
  input logic [NUM_PERIPH-1:0] swrst_i,
  input logic                  sw_fast_en_i,
  input logic                  sw_slow_en_i,
  input logic                  lp_fast_off_i,
  input logic                  lp_slow_off_i,
  input logic                  fast_override_o,
  input logic                  fast_clk_on_o,
  input logic                  slow_clk_on_o,
  input logic [NUM_PERIPH-1:0] periph_clk_en_o
);
  localparam int unsigned IW = $clog2(HOLD_CYCLES + 1);

  logic [NUM_PERIPH-1:0] eligible;
  logic                  any_req;
  logic [IW-1:0]         idle_q;

  assign eligible = master_i & ~src_slow_i & ~swrst_i;
  assign any_req  = |(eligible & busy_i);

  // edges since the last sampled request, saturating at HOLD_CYCLES
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) idle_q <= IW'(HOLD_CYCLES);
    else if (any_req) idle_q <= '0;
    else if (idle_q < IW'(HOLD_CYCLES)) idle_q <= idle_q + 1'b1;
  end

  assert_hold_expires_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (idle_q == IW'(HOLD_CYCLES)) |-> !fast_override_o);

  assert_idle_sw_ctrl_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fast_override_o |-> (fast_clk_on_o == (sw_fast_en_i && !lp_fast_off_i)));

  assert_fast_only_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fast_override_o |-> (|eligible));

  assert_device_wide_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fast_override_o |-> fast_clk_on_o);

  for (genvar c = 0; c < NUM_PERIPH; c++) begin : g_chk
    assert_req_forces_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (eligible[c] && busy_i[c]) |=> (fast_override_o || !eligible[c]));

    assert_slave_no_clk_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !master_i[c] |-> !periph_clk_en_o[c]);

    assert_fast_periph_en_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (master_i[c] && !src_slow_i[c]) |-> (periph_clk_en_o[c] == fast_clk_on_o));
  end
endmodule

bind clkreq_ctrl clkreq_ctrl_chk #(
  .NUM_PERIPH (NUM_PERIPH),
  .HOLD_CYCLES(HOLD_CYCLES)
) u_chk (.*);

// File: tb/clkreq_ctrl_bench.sv
module clkreq_ctrl_bench;
  localparam int NP    = 2;
  localparam int HOLD  = 2;
  localparam int CLK_P = 10;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NP-1:0] src_slow = '0, master = '0, busy = '0, swrst = '0;
  logic          sw_fast = 1'b0, sw_slow = 1'b0, lp_fast = 1'b0, lp_slow = 1'b0;
  logic          ovr, fast_on, slow_on;
  logic [NP-1:0] pen;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;
  int m_cnt [NP];

  always #(CLK_P/2) clk = ~clk;

  clkreq_ctrl #(.NUM_PERIPH(NP), .HOLD_CYCLES(HOLD)) u_clkreq_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .src_slow_i(src_slow), .master_i(master),
    .busy_i(busy), .swrst_i(swrst), .sw_fast_en_i(sw_fast), .sw_slow_en_i(sw_slow),
    .lp_fast_off_i(lp_fast), .lp_slow_off_i(lp_slow), .fast_override_o(ovr),
    .fast_clk_on_o(fast_on), .slow_clk_on_o(slow_on), .periph_clk_en_o(pen)
  );

  // per-peripheral hold model derived from R2/R3/R8
  always @(posedge clk or negedge rst_n) begin
    for (int c = 0; c < NP; c++) begin
      if (!rst_n || swrst[c]) m_cnt[c] <= 0;
      else if (master[c] && !src_slow[c] && busy[c]) m_cnt[c] <= HOLD;
      else if (m_cnt[c] != 0) m_cnt[c] <= m_cnt[c] - 1;
    end
  end

  task automatic chk(input string tag, input int got, input int exp);
    total++;
    if (got != exp) begin
      bad++;
      $display("FAIL %s got=%0d exp=%0d t=%0t", tag, got, exp, $time);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic settle();
    #(CLK_P/4);
  endtask

  task automatic full_check();
    logic e_ovr, e_fast, e_slow;
    logic [NP-1:0] e_pen;
    e_ovr = 1'b0;
    for (int c = 0; c < NP; c++)
      if (m_cnt[c] != 0 && master[c] && !src_slow[c] && !swrst[c]) e_ovr = 1'b1;
    e_fast = (sw_fast && !lp_fast) || e_ovr;
    e_slow = sw_slow && !lp_slow;
    for (int c = 0; c < NP; c++)
      e_pen[c] = master[c] && (src_slow[c] ? e_slow : e_fast);
    chk("R2/R3/R5/R8 override", int'(ovr), int'(e_ovr));
    chk("R4/R6 fast_on", int'(fast_on), int'(e_fast));
    chk("R10 slow_on", int'(slow_on), int'(e_slow));
    chk("R7/R9 periph_en", int'(pen), int'(e_pen));
  endtask

  task automatic apply(input int v);
    tick();
    busy     = v[1:0];
    master   = v[3:2];
    src_slow = v[5:4];
    swrst    = v[7:6];
    sw_fast  = v[8];
    sw_slow  = v[9];
    lp_fast  = v[10];
    lp_slow  = v[11];
    settle();
    full_check();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int hi;
    sw_fast = 1'b1;
    repeat (3) @(posedge clk);
    tick(); settle();
    chk("R1 override in reset", int'(ovr), 0);
    chk("R1 fast_on in reset", int'(fast_on), 1);
    rst_n = 1'b1;
    tick(); settle();
    chk("R1 override after reset", int'(ovr), 0);

    // R3: override length for busy bursts of L sampled edges
    sw_fast = 1'b0; lp_fast = 1'b1; master = 2'b01; src_slow = '0;
    for (int len = 1; len <= 4; len++) begin
      hi = 0;
      tick(); busy[0] = 1'b1;
      for (int k = 0; k < len; k++) begin
        tick(); settle();
        if (ovr) hi++;
        chk("R2 override while busy", int'(ovr), 1);
        chk("R6 fast forced on", int'(fast_on), 1);
      end
      busy[0] = 1'b0;
      for (int k = 0; k < HOLD + 3; k++) begin
        tick(); settle();
        if (ovr) hi++;
      end
      chk("R3 override length", hi, len + HOLD - 1);
    end

    // R6: second master on fast source sees forced clock
    master = 2'b11;
    tick(); busy[0] = 1'b1;
    tick(); settle();
    chk("R6 peer periph_en", int'(pen[1]), 1);

    // R8: software reset drops override at once and discards hold
    tick(); busy[0] = 1'b0; swrst[0] = 1'b1;
    settle();
    chk("R8 override same cycle", int'(ovr), 0);
    tick(); swrst[0] = 1'b0; settle();
    chk("R8 no return after release", int'(ovr), 0);

    // R5: slow source busy, no override
    tick(); src_slow = 2'b01; busy = 2'b01; master = 2'b01;
    repeat (3) tick();
    settle();
    chk("R5 slow no override", int'(ovr), 0);
    chk("R5 slow periph_en", int'(pen[0]), 0);

    // R7: busy slaves with every clock disabled
    tick(); src_slow = '0; master = '0; busy = 2'b11;
    sw_fast = 1'b0; sw_slow = 1'b0; lp_fast = 1'b1; lp_slow = 1'b1;
    repeat (3) tick();
    settle();
    chk("R7 slave override", int'(ovr), 0);
    chk("R7 slave fast_on", int'(fast_on), 0);
    chk("R7 slave periph_en", int'(pen), 0);
    tick(); busy = '0;
    repeat (HOLD + 1) tick();

    // exhaustive sweeps, two orderings
    for (int v = 0; v < 4096; v++) apply(v);
    for (int v = 0; v < 4096; v++) apply((v * 1237) % 4096);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule